// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register front end of an I/O interrupt router. Software sees only two 32-bit registers on a small memory-mapped bus: an index (select) register and a data window. The value in the index register chooses what the window reaches. It can reach an identification word, a fixed version word, an arbitration word, or one half of one of the routing entries. Each routing entry is 64 bits wide.

Every routing entry holds a vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. It also holds two status bits: delivery busy and remote IRR. Software cannot write the status bits. The delivery engine outside this block sets and clears them through a narrow status port. The full table is exported as a flat vector for that engine. Interrupt delivery and end-of-interrupt handling live elsewhere.

When a window write alters an entry in any field other than mask or polarity, the block raises a one-cycle pulse. Downstream logic uses this pulse to rebuild its trigger-mode state.

Top module: `irqwin_top`

## Requirements
- R1: Only accesses with busSize equal to 4 at byte offset 0x00 (index register) or 0x10 (window) take effect. Every other read returns 0, and every other write changes no state.
- R2: A write at offset 0x00 stores all 32 bits, and a read at offset 0x00 returns them. Only bits [7:0] of the stored value act as the window index.
- R3: Window index 0x10+2n maps to bits [31:0] of entry n, and index 0x10+2n+1 maps to bits [63:32]. Entry n is also exported on tableFlat[64n+63:64n].
- R4: Window index 0x01 reads ((NUM_ENTRIES-1)<<16)|0x11, which is 0x001F0011 by default. Writes to it are ignored.
- R5: A window write to index 0x00 keeps only bits [31:24]. Reads of index 0x00 return that field in place, with all other bits zero. Index 0x02 reads the same value and ignores writes.
- R6: A window write never changes bit 12 (delivery busy) or bit 14 (remote IRR) of an entry, except that R8 can clear bit 14.
- R7: After reset every entry is 0x0001000000010000, meaning masked and edge-triggered. The index register, identification field, rdData and tmrUpdate are all 0.
- R8: A window write that leaves bit 15 (trigger mode, 1 = level) at 0 clears bit 14 in the same update.
- R9: tmrUpdate is 1 in the cycle after a window write to an entry, when old XOR new has any bit set other than bit 16 (mask) and bit 13 (polarity).
- R10: Window indexes 0x03 to 0x0F, and indexes from 0x10+2*NUM_ENTRIES up to 0xFF, read as 0.
- R11: Read data is registered. It appears in the cycle after the read strobe and holds until the next read.
- R12: While stsValid is 1, entry stsIdx takes stsDelivBusy into bit 12 and stsRemoteIrr into bit 14. This never pulses tmrUpdate. A window write to the same entry in the same cycle merges onto the updated bits.
- R13: A window write that changes nothing, or only mask or polarity, leaves tmrUpdate at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Access strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte offset inside the block |
| busSize | input | 3 | Access size in bytes |
| busWdata | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| stsValid | input | 1 | Status update strobe from the delivery engine |
| stsIdx | input | $clog2(NUM_ENTRIES) (5) | Entry targeted by the status update |
| stsRemoteIrr | input | 1 | New remote IRR value |
| stsDelivBusy | input | 1 | New delivery busy value |
| tmrUpdate | output | 1 | Pulse asking for a trigger-mode rebuild |
| tableFlat | output | 64*NUM_ENTRIES (2048) | All entries, entry n at [64n+63:64n] |

## Verification
A wrong index decode or a wrong half select is visible at the ports right away. The window read one cycle later returns another entry's half or zero, and tableFlat shows the write landing in the wrong slot in the cycle after the write. Corrupted status bits show up on tableFlat in the cycle after the offending write, as bits 12 and 14 changing. A faulty change filter shows up as a missing or extra tmrUpdate pulse exactly one cycle after the write.

// File: rtl/irqwin_pkg.sv
package irqwin_pkg;

  localparam int unsigned WORD_W       = 32;
  localparam int unsigned ENT_W        = 64;
  localparam int unsigned ACCESS_BYTES = 4;
  localparam int unsigned SEL_OFS      = 'h00;
  localparam int unsigned WIN_OFS      = 'h10;

  localparam int unsigned IDX_ID   = 'h00;
  localparam int unsigned IDX_VER  = 'h01;
  localparam int unsigned IDX_ARB  = 'h02;
  localparam int unsigned IDX_TBL  = 'h10;

  localparam int unsigned BIT_DBUSY = 12;
  localparam int unsigned BIT_POL   = 13;
  localparam int unsigned BIT_RIRR  = 14;
  localparam int unsigned BIT_TRIG  = 15;
  localparam int unsigned BIT_MASK  = 16;

  localparam logic [ENT_W-1:0] ENTRY_RESET = 64'h0001_0000_0001_0000;
  localparam logic [ENT_W-1:0] RO_BITS     = (64'd1 << BIT_DBUSY) | (64'd1 << BIT_RIRR);
  localparam logic [ENT_W-1:0] QUIET_BITS  = (64'd1 << BIT_MASK) | (64'd1 << BIT_POL);

  typedef struct packed {
    logic       anyRd;
    logic       selRd;
    logic       idWr;
    logic       idRd;
    logic       verRd;
    logic       arbRd;
    logic       tblWr;
    logic       tblRd;
    logic       tblHigh;
    logic [6:0] tblIdx;
  } winStrobe_t;

endpackage

// File: rtl/irqwin_ctrl.sv
module irqwin_ctrl
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] selValue,
  output winStrobe_t        strobe
);

  localparam int unsigned TBL_END = IDX_TBL + 2 * NUM_ENTRIES;

  logic accessOk, selHit, winHit, winRd, winWr, inTbl;
  logic [7:0] idx, tblOfs;
  logic [WORD_W-1:0] selQ;

  assign accessOk = busEn && (busSize == 3'(ACCESS_BYTES));
  assign selHit   = accessOk && (busAddr == ADDR_W'(SEL_OFS));
  assign winHit   = accessOk && (busAddr == ADDR_W'(WIN_OFS));
  assign winRd    = winHit && !busWe;
  assign winWr    = winHit && busWe;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= '0;
    else if (selHit && busWe) selQ <= busWdata;
  end

  assign selValue = selQ;
  assign idx      = selQ[7:0];
  assign inTbl    = (32'(idx) >= IDX_TBL) && (32'(idx) < TBL_END);
  assign tblOfs   = idx - 8'(IDX_TBL);

  always_comb begin
    strobe         = '0;
    strobe.anyRd   = busEn && !busWe;
    strobe.selRd   = selHit && !busWe;
    strobe.idWr    = winWr && (idx == 8'(IDX_ID));
    strobe.idRd    = winRd && (idx == 8'(IDX_ID));
    strobe.verRd   = winRd && (idx == 8'(IDX_VER));
    strobe.arbRd   = winRd && (idx == 8'(IDX_ARB));
    strobe.tblWr   = winWr && inTbl;
    strobe.tblRd   = winRd && inTbl;
    strobe.tblHigh = tblOfs[0];
    strobe.tblIdx  = tblOfs[7:1];
  end

endmodule

// File: rtl/irqwin_dp.sv
module irqwin_dp
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ID_LSB      = 24,
  parameter int unsigned ID_W        = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  winStrobe_t                     strobe,
  input  logic [WORD_W-1:0]              busWdata,
  input  logic [WORD_W-1:0]              selValue,
  input  logic                           stsValid,
  input  logic [IDX_W-1:0]               stsIdx,
  input  logic                           stsRemoteIrr,
  input  logic                           stsDelivBusy,
  output logic [WORD_W-1:0]              rdData,
  output logic                           tmrUpdate,
  output logic [NUM_ENTRIES*ENT_W-1:0]   tableFlat
);

  localparam logic [WORD_W-1:0] VER_VAL = WORD_W'((NUM_ENTRIES - 1) << 16) | WORD_W'(32'h11);

  logic [NUM_ENTRIES-1:0][ENT_W-1:0] entFlat;
  logic [NUM_ENTRIES-1:0]            chgVec;
  logic [ID_W-1:0]                   idQ;
  logic [WORD_W-1:0]                 idWord, rdNext;
  logic [ENT_W-1:0]                  rdEnt;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic             stsHit, wrHit;
    logic [ENT_W-1:0] entQ, base, wide, merged, nxt;

    always_comb begin
      stsHit = stsValid && (stsIdx == IDX_W'(e));
      wrHit  = strobe.tblWr && (strobe.tblIdx == 7'(e));
      base   = entQ;
      if (stsHit) begin
        base[BIT_DBUSY] = stsDelivBusy;
        base[BIT_RIRR]  = stsRemoteIrr;
      end
      wide   = strobe.tblHigh ? {busWdata, base[WORD_W-1:0]} : {base[ENT_W-1:WORD_W], busWdata};
      merged = (wide & ~RO_BITS) | (base & RO_BITS);
      if (!merged[BIT_TRIG]) merged[BIT_RIRR] = 1'b0;
      nxt = wrHit ? merged : base;
    end

    always_ff @(posedge clk) begin
      if (!rstN) entQ <= ENTRY_RESET;
      else       entQ <= nxt;
    end

    assign entFlat[e] = entQ;
    assign chgVec[e]  = wrHit && (|((base ^ nxt) & ~QUIET_BITS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) idQ <= '0;
    else if (strobe.idWr) idQ <= busWdata[ID_LSB +: ID_W];
  end

  assign idWord = WORD_W'(idQ) << ID_LSB;
  assign rdEnt  = entFlat[strobe.tblIdx[IDX_W-1:0]];

  always_comb begin
    rdNext = '0;
    if (strobe.selRd)                     rdNext = selValue;
    else if (strobe.idRd || strobe.arbRd) rdNext = idWord;
    else if (strobe.verRd)                rdNext = VER_VAL;
    else if (strobe.tblRd)                rdNext = strobe.tblHigh ? rdEnt[ENT_W-1:WORD_W] : rdEnt[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      tmrUpdate <= 1'b0;
    end else begin
      if (strobe.anyRd) rdData <= rdNext;
      tmrUpdate <= |chgVec;
    end
  end

  assign tableFlat = entFlat;

endmodule

// File: rtl/irqwin_top.sv
module irqwin_top
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned ID_LSB      = 24,
  parameter int unsigned ID_W        = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busEn,
  input  logic                         busWe,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [2:0]                   busSize,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  rdData,
  input  logic                         stsValid,
  input  logic [IDX_W-1:0]             stsIdx,
  input  logic                         stsRemoteIrr,
  input  logic                         stsDelivBusy,
  output logic                         tmrUpdate,
  output logic [NUM_ENTRIES*64-1:0]    tableFlat
);

  winStrobe_t        strobe;
  logic [WORD_W-1:0] selValue;

  irqwin_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .selValue(selValue), .strobe(strobe)
  );

  irqwin_dp #(.NUM_ENTRIES(NUM_ENTRIES), .ID_LSB(ID_LSB), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .selValue(selValue),
    .stsValid(stsValid), .stsIdx(stsIdx), .stsRemoteIrr(stsRemoteIrr),
    .stsDelivBusy(stsDelivBusy), .rdData(rdData), .tmrUpdate(tmrUpdate),
    .tableFlat(tableFlat)
  );

endmodule

// File: rtl/irqwin_chk.sv
module irqwin_chk
  import irqwin_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ADDR_W      = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         busEn,
  input logic                         busWe,
  input logic [ADDR_W-1:0]            busAddr,
  input logic [2:0]                   busSize,
  input logic [31:0]                  rdData,
  input logic                         stsValid,
  input logic [IDX_W-1:0]             stsIdx,
  input logic                         tmrUpdate,
  input logic [NUM_ENTRIES*64-1:0]    tableFlat,
  input logic [31:0]                  selValue
);

  localparam int unsigned TBL_END = IDX_TBL + 2 * NUM_ENTRIES;
  localparam logic [31:0] VER_EXP = 32'((NUM_ENTRIES - 1) << 16) | 32'h11;

  logic okSize, selAcc, winAcc, winRead, winWrite, inTbl, noMatch;
  logic [7:0] idx, ofs;

  assign okSize   = busSize == 3'(ACCESS_BYTES);
  assign selAcc   = okSize && busAddr == ADDR_W'(SEL_OFS);
  assign winAcc   = okSize && busAddr == ADDR_W'(WIN_OFS);
  assign winRead  = busEn && !busWe && winAcc;
  assign winWrite = busEn && busWe && winAcc;
  assign idx      = selValue[7:0];
  assign ofs      = idx - 8'(IDX_TBL);
  assign inTbl    = 32'(idx) >= IDX_TBL && 32'(idx) < TBL_END;
  assign noMatch  = !inTbl && 32'(idx) > IDX_ARB;

  // R1
  p_bad_access_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWe && !selAcc && !winAcc) |=> rdData == 32'h0);

  // R2
  p_sel_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWe && selAcc) |=> rdData == $past(selValue));

  // R4
  p_version_r4: assert property (@(posedge clk) disable iff (!rstN)
    (winRead && idx == 8'(IDX_VER)) |=> rdData == VER_EXP);

  // R10
  p_unmatched_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (winRead && noMatch) |=> rdData == 32'h0);

  // R9
  p_flag_needs_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    tmrUpdate |-> $past(winWrite && inTbl));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic hitE, stsE;
    assign hitE = winWrite && inTbl && ofs[7:1] == 7'(e);
    assign stsE = stsValid && stsIdx == IDX_W'(e);

    // R6
    p_status_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
      (hitE && !stsE) |=> (tableFlat[e*64+BIT_DBUSY] == $past(tableFlat[e*64+BIT_DBUSY])) &&
                          (!tableFlat[e*64+BIT_RIRR] || $past(tableFlat[e*64+BIT_RIRR])));

    // R8
    p_edge_clears_irr_r8: assert property (@(posedge clk) disable iff (!rstN)
      hitE |=> !(tableFlat[e*64+BIT_RIRR] && !tableFlat[e*64+BIT_TRIG]));
  end

endmodule

bind irqwin_top irqwin_chk #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
  .busSize(busSize), .rdData(rdData), .stsValid(stsValid), .stsIdx(stsIdx),
  .tmrUpdate(tmrUpdate), .tableFlat(tableFlat), .selValue(selValue)
);

// File: tb/sim_irqwin_top.sv
module sim_irqwin_top;

  localparam int N = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busEn = 1'b0, busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [2:0] busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdData;
  logic stsValid = 1'b0, stsRemoteIrr = 1'b0, stsDelivBusy = 1'b0;
  logic [4:0] stsIdx = '0;
  logic tmrUpdate;
  logic [N*64-1:0] tableFlat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] mdl [N];

  always #10 clk = ~clk;

  irqwin_top u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .rdData(rdData), .stsValid(stsValid),
    .stsIdx(stsIdx), .stsRemoteIrr(stsRemoteIrr), .stsDelivBusy(stsDelivBusy),
    .tmrUpdate(tmrUpdate), .tableFlat(tableFlat)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic we, input logic [7:0] addr, input logic [2:0] size,
                       input logic [31:0] wd, output logic [31:0] rd, output logic tmr);
    @(negedge clk);
    busEn = 1'b1; busWe = we; busAddr = addr; busSize = size; busWdata = wd;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
    rd = rdData; tmr = tmrUpdate;
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [31:0] d, output logic tmr);
    logic [31:0] rd;
    logic t;
    busOp(1'b1, 8'h00, 3'd4, {24'h0, idx}, rd, t);
    busOp(1'b1, 8'h10, 3'd4, d, rd, tmr);
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [31:0] d);
    logic [31:0] rd;
    logic t;
    busOp(1'b1, 8'h00, 3'd4, {24'h0, idx}, rd, t);
    busOp(1'b0, 8'h10, 3'd4, 32'h0, d, t);
  endtask

  // expected entry after a window write (R6, R8) and expected pulse (R9, R13)
  task automatic tblWrite(input int e, input bit hi, input logic [31:0] d);
    logic [63:0] nw;
    logic exp, t;
    nw = mdl[e];
    if (hi) nw[63:32] = d;
    else    nw[31:0]  = (d & ~32'h5000) | (mdl[e][31:0] & 32'h5000);
    if (!nw[15]) nw[14] = 1'b0;
    exp = |((nw ^ mdl[e]) & ~64'h0001_2000);
    mdl[e] = nw;
    wrReg(8'(16 + 2 * e + (hi ? 1 : 0)), d, t);
    chk($sformatf("R9/R13 pulse entry %0d", e), 64'(t), 64'(exp));
    chk($sformatf("R3 export entry %0d", e), tableFlat[e*64 +: 64], mdl[e]);
  endtask

  task automatic stsWrite(input int e, input logic irr, input logic busy);
    @(negedge clk);
    stsValid = 1'b1; stsIdx = 5'(e); stsRemoteIrr = irr; stsDelivBusy = busy;
    @(negedge clk);
    stsValid = 1'b0;
    mdl[e][12] = busy; mdl[e][14] = irr;
    chk("R12 status no pulse", 64'(tmrUpdate), 64'h0);
    chk("R12 status bits", tableFlat[e*64 +: 64], mdl[e]);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, hold;
    logic t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 reset state
    chk("R7 rdData reset", 64'(rdData), 64'h0);
    chk("R7 tmrUpdate reset", 64'(tmrUpdate), 64'h0);
    for (int e = 0; e < N; e++) begin
      mdl[e] = 64'h0001_0000_0001_0000;
      chk("R7 entry reset", tableFlat[e*64 +: 64], mdl[e]);
    end
    busOp(1'b0, 8'h00, 3'd4, 32'h0, d, t);
    chk("R7 select reset", 64'(d), 64'h0);
    rdReg(8'h00, d);
    chk("R7 id reset", 64'(d), 64'h0);

    // R3 R7 every half via window
    for (int i = 0; i < 2 * N; i++) begin
      rdReg(8'(16 + i), d);
      chk("R3 reset half read", 64'(d), 64'h0001_0000);
    end

    // R4 version
    rdReg(8'h01, d);
    chk("R4 version", 64'(d), 64'(((N - 1) << 16) | 32'h11));
    wrReg(8'h01, 32'hFFFF_FFFF, t);
    rdReg(8'h01, d);
    chk("R4 version after write", 64'(d), 64'h001F_0011);

    // R5 identification and arbitration
    wrReg(8'h00, 32'hABCD_EF12, t);
    rdReg(8'h00, d);
    chk("R5 id field", 64'(d), 64'hAB00_0000);
    rdReg(8'h02, d);
    chk("R5 arb mirror", 64'(d), 64'hAB00_0000);
    wrReg(8'h02, 32'h1100_0000, t);
    rdReg(8'h00, d);
    chk("R5 arb read-only", 64'(d), 64'hAB00_0000);

    // R2 full select value, low byte decoded
    busOp(1'b1, 8'h00, 3'd4, 32'hFFFF_FF01, d, t);
    busOp(1'b0, 8'h00, 3'd4, 32'h0, d, t);
    chk("R2 select readback", 64'(d), 64'hFFFF_FF01);
    busOp(1'b0, 8'h10, 3'd4, 32'h0, d, t);
    chk("R2 low byte decode", 64'(d), 64'h001F_0011);

    // R11 hold across a write
    hold = d;
    busOp(1'b1, 8'h00, 3'd4, 32'h0000_0003, d, t);
    chk("R11 rdData holds", 64'(rdData), 64'(hold));

    // R3 R6 R8 R9 sweep over all entries
    for (int e = 0; e < N; e++) begin
      d = 32'((e * 37) & 8'hFF) | 32'((e % 8) << 8) | 32'((e & 1) << 11) | 32'h5000 |
          ((e & 2) != 0 ? 32'h8000 : 32'h0) | ((e & 4) != 0 ? 32'h1_0000 : 32'h0) |
          ((e & 8) != 0 ? 32'h2000 : 32'h0);
      tblWrite(e, 1'b0, d);
      tblWrite(e, 1'b1, 32'(e << 24) | 32'(e * 3));
    end
    for (int e = 0; e < N; e++) begin
      rdReg(8'(16 + 2 * e), d);
      chk($sformatf("R3 R6 low read entry %0d", e), 64'(d), 64'(mdl[e][31:0]));
      rdReg(8'(16 + 2 * e + 1), d);
      chk($sformatf("R3 high read entry %0d", e), 64'(d), 64'(mdl[e][63:32]));
    end

    // R12 status, R6 protection, R8 edge clear
    tblWrite(5, 1'b0, 32'h0000_8030);
    stsWrite(5, 1'b1, 1'b1);
    rdReg(8'h1A, d);
    chk("R12 status visible", 64'(d), 64'h0000_D030);
    tblWrite(5, 1'b0, 32'h0000_8031);
    chk("R6 irr kept level", 64'(tableFlat[5*64 + 14]), 64'h1);
    tblWrite(5, 1'b1, 32'h7700_0000);
    chk("R6 busy kept", 64'(tableFlat[5*64 + 12]), 64'h1);
    tblWrite(5, 1'b0, 32'h0000_0031);
    chk("R8 irr cleared on edge", 64'(tableFlat[5*64 + 14]), 64'h0);
    rdReg(8'h1A, d);
    chk("R8 low read after edge", 64'(d), 64'h0000_1031);

    // R13 quiet changes
    tblWrite(6, 1'b0, 32'h0000_8044);
    tblWrite(6, 1'b0, 32'h0000_8044);
    tblWrite(6, 1'b0, 32'h0001_8044);
    tblWrite(6, 1'b0, 32'h0001_A044);
    tblWrite(6, 1'b0, 32'h0001_A045);

    // R1 bad size or offset
    busOp(1'b0, 8'h10, 3'd2, 32'h0, d, t);
    chk("R1 short read zero", 64'(d), 64'h0);
    busOp(1'b0, 8'h04, 3'd4, 32'h0, d, t);
    chk("R1 odd offset read zero", 64'(d), 64'h0);
    busOp(1'b1, 8'h00, 3'd4, 32'h0000_0014, d, t);
    busOp(1'b1, 8'h00, 3'd1, 32'h0000_0001, d, t);
    busOp(1'b1, 8'h20, 3'd4, 32'h0000_0001, d, t);
    busOp(1'b0, 8'h00, 3'd4, 32'h0, d, t);
    chk("R1 ignored select write", 64'(d), 64'h14);
    busOp(1'b1, 8'h10, 3'd2, 32'h0000_00EE, d, t);
    chk("R1 ignored window write", tableFlat[2*64 +: 64], mdl[2]);

    // R10 unmatched indexes
    rdReg(8'h03, d); chk("R10 idx 03", 64'(d), 64'h0);
    rdReg(8'h0F, d); chk("R10 idx 0F", 64'(d), 64'h0);
    rdReg(8'h50, d); chk("R10 idx 50", 64'(d), 64'h0);
    rdReg(8'hFF, d); chk("R10 idx FF", 64'(d), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule